// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block queues pending read requests for a single memory channel with four banks and decides which one goes to the memory next. Every bank remembers the row it currently holds open. A request to that row is served quickly as a hit. A request to any other row is a miss: it costs twice as long and leaves the new row open.

A request carries a bank, a row and the ID of the core that sent it. It enters through a valid/ready port and receives an arrival sequence number when it is accepted. Each cycle, at most one queued request is started. The choice is made in three tiers:

1. Requests from cores marked latency-sensitive in a per-core flag vector come first.
2. Within a tier, row hits come before misses.
3. Remaining ties go to the earliest arrival.

Banks work in parallel. However, the channel's data path carries only one result per cycle. When an access finishes, a completion port reports the bank, row, core, hit/miss outcome, service latency and arrival number.

Top module: `rowhit_sched`

## Requirements
- R1: The queue holds up to 8 requests. `req_ready` is low exactly when 8 are held, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: After reset no bank has an open row, so the first access to each bank is a miss. Afterwards an access is a hit (`done_hit`=1) exactly when its row equals the row last started on that bank.
- R3: Starting an access makes its row the bank's open row, whatever the outcome.
- R4: An access started at clock edge t produces a one-cycle `done_valid` pulse after edge t+L. L is HIT_LAT for a hit and MISS_LAT for a miss, and `done_lat` reports L.
- R5: A busy bank takes no new access before the edge at which its current access completes. A new access may start at that same edge.
- R6: At most one access completes per cycle. A request whose completion edge would coincide with another bank's completion is held back that cycle.
- R7: Eligible requests from cores whose `prio_core` bit is 1 are started ahead of all other eligible requests.
- R8: Within the same priority tier, an eligible hit is started ahead of an eligible miss.
- R9: Among remaining ties, the request accepted earliest is started first.
- R10: `done_age` equals the request's arrival number. Arrival numbers count accepted requests from 0 after reset, modulo 2^AGE_W.
- R11: At most one access starts per cycle. A request accepted at an edge is not eligible until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue has room |
| req_bank | input | $clog2(NBANKS) | Target bank |
| req_row | input | ROW_W | Target row |
| req_core | input | $clog2(NCORES) | Sending core |
| prio_core | input | NCORES | Per-core latency-sensitive flag |
| done_valid | output | 1 | Completion pulse |
| done_bank | output | $clog2(NBANKS) | Bank of completed access |
| done_row | output | ROW_W | Row of completed access |
| done_core | output | $clog2(NCORES) | Core of completed access |
| done_hit | output | 1 | 1 if the access was a row hit |
| done_lat | output | $clog2(MISS_LAT+2) | Service latency in cycles |
| done_age | output | AGE_W | Arrival number of the request |

## Verification
The assertions assume that the inputs hold steady between clock edges. They also assume that `prio_core` is only read during selection, so it may change freely between cycles. Arrival ordering relies on fewer than 2^AGE_W acceptances occurring while one request waits. The stimulus changes inputs only at falling edges and sends a few hundred requests in total, so the arrival counter never wraps around a waiting request. It uses only four rows per bank, which produces frequent hits, misses, bank stalls and completion-slot clashes.

// File: rtl/rowhit_sched.sv
module rowhit_sched #(
  parameter int NBANKS   = 4,
  parameter int DEPTH    = 8,
  parameter int ROW_W    = 12,
  parameter int NCORES   = 4,
  parameter int AGE_W    = 16,
  parameter int HIT_LAT  = 200,
  parameter int MISS_LAT = 400
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(NBANKS)-1:0]     req_bank,
  input  logic [ROW_W-1:0]              req_row,
  input  logic [$clog2(NCORES)-1:0]     req_core,
  input  logic [NCORES-1:0]             prio_core,
  output logic                          done_valid,
  output logic [$clog2(NBANKS)-1:0]     done_bank,
  output logic [ROW_W-1:0]              done_row,
  output logic [$clog2(NCORES)-1:0]     done_core,
  output logic                          done_hit,
  output logic [$clog2(MISS_LAT+2)-1:0] done_lat,
  output logic [AGE_W-1:0]              done_age
);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int CORE_W = $clog2(NCORES);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LAT_W  = $clog2(MISS_LAT + 2);
  localparam logic [LAT_W-1:0] HIT_L  = LAT_W'(HIT_LAT);
  localparam logic [LAT_W-1:0] MISS_L = LAT_W'(MISS_LAT);
  localparam logic [LAT_W-1:0] ONE_L  = LAT_W'(1);

  logic [DEPTH-1:0]  e_vld;
  logic [BANK_W-1:0] e_bank [DEPTH];
  logic [ROW_W-1:0]  e_row  [DEPTH];
  logic [CORE_W-1:0] e_core [DEPTH];
  logic [AGE_W-1:0]  e_age  [DEPTH];
  logic [AGE_W-1:0]  arr_cnt;

  logic [LAT_W-1:0]  b_cnt  [NBANKS];
  logic [NBANKS-1:0] b_open;
  logic [NBANKS-1:0] b_hit;
  logic [ROW_W-1:0]  b_row  [NBANKS];
  logic [CORE_W-1:0] b_core [NBANKS];
  logic [AGE_W-1:0]  b_age  [NBANKS];

  logic              sel_vld, sel_hit;
  logic [IDX_W-1:0]  sel_idx, slot;
  logic [BANK_W-1:0] iss_bank, fin_bank;
  logic [LAT_W-1:0]  sel_lat;
  logic [NBANKS-1:0] fin;
  logic              acc;

  assign req_ready = ~&e_vld;
  assign acc       = req_valid && req_ready;
  assign iss_bank  = e_bank[sel_idx];
  assign sel_lat   = sel_hit ? HIT_L : MISS_L;

  always_comb begin
    logic             hit, ok;
    logic [LAT_W-1:0] lat;
    logic [AGE_W+1:0] score, best;
    sel_vld = 1'b0;
    sel_hit = 1'b0;
    sel_idx = '0;
    best    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit   = b_open[e_bank[i]] && (b_row[e_bank[i]] == e_row[i]);
      lat   = hit ? HIT_L : MISS_L;
      ok    = e_vld[i] && (b_cnt[e_bank[i]] <= ONE_L);
      for (int k = 0; k < NBANKS; k++)
        if (b_cnt[k] == lat + ONE_L) ok = 1'b0;
      score = {prio_core[e_core[i]], hit, arr_cnt - e_age[i]};
      if (ok && (!sel_vld || score > best)) begin
        sel_vld = 1'b1;
        sel_idx = IDX_W'(i);
        sel_hit = hit;
        best    = score;
      end
    end
  end

  always_comb begin
    slot = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_vld[i]) slot = IDX_W'(i);
  end

  always_comb begin
    fin_bank = '0;
    for (int b = 0; b < NBANKS; b++) begin
      fin[b] = (b_cnt[b] == ONE_L);
      if (fin[b]) fin_bank = BANK_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld   <= '0;
      arr_cnt <= '0;
    end else begin
      if (sel_vld) e_vld[sel_idx] <= 1'b0;
      if (acc) begin
        e_vld[slot]  <= 1'b1;
        e_bank[slot] <= req_bank;
        e_row[slot]  <= req_row;
        e_core[slot] <= req_core;
        e_age[slot]  <= arr_cnt;
        arr_cnt      <= arr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_open <= '0;
      b_hit  <= '0;
      for (int b = 0; b < NBANKS; b++) begin
        b_cnt[b]  <= '0;
        b_row[b]  <= '0;
        b_core[b] <= '0;
        b_age[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NBANKS; b++) begin
        if (sel_vld && iss_bank == BANK_W'(b)) begin
          b_cnt[b]  <= sel_lat;
          b_open[b] <= 1'b1;
          b_hit[b]  <= sel_hit;
          b_row[b]  <= e_row[sel_idx];
          b_core[b] <= e_core[sel_idx];
          b_age[b]  <= e_age[sel_idx];
        end else if (b_cnt[b] != '0) begin
          b_cnt[b] <= b_cnt[b] - ONE_L;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_bank  <= '0;
      done_row   <= '0;
      done_core  <= '0;
      done_hit   <= 1'b0;
      done_lat   <= '0;
      done_age   <= '0;
    end else begin
      done_valid <= |fin;
      if (|fin) begin
        done_bank <= fin_bank;
        done_row  <= b_row[fin_bank];
        done_core <= b_core[fin_bank];
        done_hit  <= b_hit[fin_bank];
        done_lat  <= b_hit[fin_bank] ? HIT_L : MISS_L;
        done_age  <= b_age[fin_bank];
      end
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $countones(e_vld) <= $countones($past(e_vld)));
  // R2
  cold_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld && !b_open[iss_bank] |-> !sel_hit);
  // R4
  done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_lat == (done_hit ? HIT_L : MISS_L));
  // R5
  bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |-> b_cnt[iss_bank] <= ONE_L);
  // R6
  single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin));
endmodule

// File: tb/rowhit_sched_test.sv
module rowhit_sched_test;
  localparam int HIT = 5;
  localparam int MISS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_bank = '0, req_core = '0;
  logic [11:0] req_row = '0;
  logic [3:0] prio_core = '0;
  logic done_valid, done_hit;
  logic [1:0] done_bank, done_core;
  logic [11:0] done_row;
  logic [3:0] done_lat;
  logic [15:0] done_age;

  rowhit_sched #(.HIT_LAT(HIT), .MISS_LAT(MISS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_core(req_core), .prio_core(prio_core),
    .done_valid(done_valid), .done_bank(done_bank), .done_row(done_row),
    .done_core(done_core), .done_hit(done_hit), .done_lat(done_lat), .done_age(done_age));

  always #5 clk = ~clk;

  typedef struct { int bank; int row; int core; int age; } ent_t;
  ent_t q[$];
  int bcnt[4], bopen[4], brow[4], bcore[4], bage[4], bhit[4];
  int acc_n = 0;
  bit e_done = 0;
  int e_bank, e_row, e_core, e_hit, e_lat, e_age;
  int checks = 0, errors = 0, hits_seen = 0, prio_seen = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int k = 0; k < 4; k++) begin bcnt[k] = 0; bopen[k] = -1; end
      acc_n = 0; e_done = 0;
    end else begin
      int best, bkey, bl, bh;
      bit take;
      best = -1; bkey = -1; bl = 0; bh = 0;
      take = req_valid && (q.size() < 8);
      for (int i = 0; i < q.size(); i++) begin
        int b, h, l, key;
        bit clash;
        b = q[i].bank;
        h = (bopen[b] == q[i].row) ? 1 : 0;
        l = h ? HIT : MISS;
        clash = 0;
        for (int k = 0; k < 4; k++) if (bcnt[k] == l + 1) clash = 1;
        key = (prio_core[q[i].core] ? 2 : 0) + h;
        if (bcnt[b] <= 1 && !clash && key > bkey) begin
          best = i; bkey = key; bl = l; bh = h;
        end
      end
      e_done = 0;
      for (int k = 0; k < 4; k++) begin
        if (bcnt[k] == 1) begin
          e_done = 1; e_bank = k; e_row = brow[k]; e_core = bcore[k];
          e_hit = bhit[k]; e_lat = bhit[k] ? HIT : MISS; e_age = bage[k];
        end
        if (bcnt[k] > 0) bcnt[k]--;
      end
      if (best >= 0) begin
        int b;
        b = q[best].bank;
        bcnt[b] = bl; bopen[b] = q[best].row; brow[b] = q[best].row;
        bcore[b] = q[best].core; bage[b] = q[best].age; bhit[b] = bh;
        if (bkey >= 2) prio_seen++;
        q.delete(best);
      end
      if (take) begin
        ent_t n;
        n.bank = int'(req_bank); n.row = int'(req_row); n.core = int'(req_core); n.age = acc_n;
        acc_n++;
        q.push_back(n);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (q.size() < 8), "R1 req_ready", int'(req_ready), int'(q.size() < 8));
      chk(done_valid == e_done, "R4 R5 R6 R11 done_valid", int'(done_valid), int'(e_done));
      if (e_done && done_valid) begin
        chk(int'(done_hit) == e_hit, "R2 R3 R8 done_hit", int'(done_hit), e_hit);
        chk(int'(done_lat) == e_lat, "R4 done_lat", int'(done_lat), e_lat);
        chk(int'(done_age) == e_age, "R7 R8 R9 R10 done_age", int'(done_age), e_age);
        chk(int'(done_bank) == e_bank, "R2 done_bank", int'(done_bank), e_bank);
        chk(int'(done_row) == e_row, "R3 done_row", int'(done_row), e_row);
        chk(int'(done_core) == e_core, "R7 done_core", int'(done_core), e_core);
        if (done_hit) hits_seen++;
      end
    end
  end

  task automatic push(input int b, input int r, input int c);
    req_valid = 1'b1;
    req_bank = 2'(b); req_row = 12'(r); req_core = 2'(c);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic drain;
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      bit busy;
      busy = (q.size() != 0);
      for (int k = 0; k < 4; k++) if (bcnt[k] != 0) busy = 1;
      if (!busy && !done_valid) break;
      @(negedge clk);
    end
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R4 reset state
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(done_valid == 1'b0, "R4 reset done", int'(done_valid), 0);
    // R2 R3 cold miss, then hit, then miss
    push(0, 5, 0); idle(1); drain;
    push(0, 5, 1); drain;
    push(0, 6, 1); drain;
    // R1 R5 R6 fill past capacity
    for (int i = 0; i < 12; i++) push(i % 2, i % 3, i % 4);
    drain;
    // R7 prioritised core
    prio_core = 4'b0100;
    for (int i = 0; i < 10; i++) push(i % 4, i % 2, (i % 3 == 0) ? 2 : 1);
    drain;
    // R8 R9 mixed hits and misses on one bank
    prio_core = '0;
    for (int i = 0; i < 8; i++) push(1, (i % 3 == 0) ? 7 : i, 0);
    drain;
    // R6 R11 random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) prio_core = 4'($urandom_range(0, 15));
      push($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
    end
    drain;
    chk(hits_seen > 0, "R8 hits observed", hits_seen, 1);
    chk(prio_seen > 0, "R7 priority observed", prio_seen, 1);
    chk(q.size() == 0 && req_ready, "R1 empty after drain", q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R4 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule